// File: doc/BRIEF.md
# Multi-Channel Frequency and Event Counter

This block counts rising edges on eighteen already-synchronized input channels at once. Each channel has its own saturating counter. A shared time-base counter runs on the reference clock. A measurement begins with a start pulse, which also captures the configuration inputs: the measurement kind, the gate selection and the pattern settings. The measurement ends either when a gate window expires or when a stop pulse arrives. At the end, every result is copied into holding registers and a single done pulse is raised.

Three kinds of measurement are supported:
- **Direct counting** counts edges inside a gate window of fixed length.
- **Reciprocal counting** aligns the window of each channel to that channel's own edges. It reports whole input periods together with the reference ticks they span, so the host can compute the period as ticks divided by periods without a fractional-edge error.
- **Event counting** runs freely until it is stopped. It can be restricted so that edges are counted only while a masked pattern on the eight lowest channels matches.

The three finite gate lengths are parameters given in reference-clock cycles. Their defaults correspond to 100 ms, 1 s and 10 s at 100 MHz. A simulation can set them much shorter.

Top module: `fc_multi_counter`

## Requirements
- R1: After reset, busy and done are low, and res_time, every res_cnt slice, every res_ticks slice and res_ovf are zero.
- R2: An edge on a channel is a clock cycle in which the channel input is 1 and its value in the previous cycle was 0. Each channel counts only its own edges, and all channels count at the same time.
- R3: In direct mode (cfg_mode 0; the value 3 is also treated as direct), cfg_gate 0, 1 or 2 selects a window of GATE_S_CYC, GATE_M_CYC or GATE_L_CYC cycles. Edges are counted over exactly that many clock edges after the start edge. res_time then equals the window length, and done rises after window+1 clock edges.
- R4: cfg_gate 3 gives an infinite gate. The measurement runs until a stop pulse, and the edge sampled together with stop is still counted. res_time equals the number of counted clock edges.
- R5: In reciprocal mode (cfg_mode 1), each channel opens on its first edge after start. After the gate has expired, the channel closes on its next edge. Its res_cnt slice is the number of whole periods counted and its res_ticks slice is the time-base distance between the opening and closing edges. A channel with no edge before expiry closes with both values at 0. The measurement ends once every channel is closed.
- R6: In event mode (cfg_mode 2), the gate selection is ignored and counting continues until stop.
- R7: In event mode with cfg_pat_en set, an edge is counted only if, in the same cycle, ((ch_in[7:0] XOR cfg_pat_val) AND cfg_pat_mask) is zero.
- R8: Counters saturate at all-ones and never wrap. res_ovf is 1 when the time base or any channel counter was at all-ones at the end of the measurement.
- R9: done is high for exactly one cycle per measurement, and busy is low while done is high. The result outputs change only in the cycle where done rises, and they hold their values while a later measurement is running.
- R10: The configuration is captured at the accepted start. Changes to the configuration inputs, and further start pulses, while busy have no effect on the measurement in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| ch_in | input | NCH | Synchronized channel inputs |
| cfg_mode | input | 2 | 0 direct, 1 reciprocal, 2 event, 3 direct |
| cfg_gate | input | 2 | 0 short, 1 medium, 2 long, 3 infinite |
| cfg_pat_en | input | 1 | Pattern-qualified event counting |
| cfg_pat_mask | input | PW | Pattern bits that take part in the match |
| cfg_pat_val | input | PW | Pattern values to match |
| start | input | 1 | Begin a measurement when idle |
| stop | input | 1 | End the running measurement |
| busy | output | 1 | A measurement is in progress |
| done | output | 1 | One-cycle pulse: results updated |
| res_ovf | output | 1 | A counter saturated |
| res_time | output | CW | Time-base count at the end |
| res_cnt | output | NCH*CW | Per-channel edge or period counts, channel i at [i*CW +: CW] |
| res_ticks | output | NCH*CW | Per-channel reciprocal tick spans |

## Verification
Every channel carries a square wave of its own period, from 2 to 8 cycles, at its own phase. In some runs a few channels are held low. This separates per-channel counting from any cross-talk between channels and exposes off-by-one errors at the window edges. Each finite gate is swept in direct mode and compared with an edge sum computed over the exact window. The stop-ended runs check that the final edge is included.

Two different masks and values are applied to the event pattern, which distinguishes a correct match from one that ignores the mask or the value. The reciprocal runs check that the tick span is an exact multiple of each channel's period and that it falls near the gate length. A long event run drives the time base into saturation.

// File: rtl/fc_pkg.sv
package fc_pkg;

    typedef enum logic [1:0] {
        M_DIRECT = 2'd0,
        M_RECIP  = 2'd1,
        M_EVENT  = 2'd2,
        M_RSVD   = 2'd3
    } meas_mode_e;

    typedef enum logic [1:0] {
        G_SHORT = 2'd0,
        G_MID   = 2'd1,
        G_LONG  = 2'd2,
        G_INF   = 2'd3
    } gate_sel_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_SNAP = 2'd2
    } ctl_state_e;

    typedef struct packed {
        meas_mode_e mode;
        gate_sel_e  gate;
        logic       pat_en;
    } meas_cfg_t;

    function automatic logic is_direct(input meas_mode_e m);
        return (m != M_RECIP) && (m != M_EVENT);
    endfunction

endpackage

// File: rtl/fc_chan.sv
module fc_chan #(
    parameter int CW = 64
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          din,
    input  logic          run,
    input  logic          clr,
    input  logic          cnt_en,
    input  logic          recip,
    input  logic          expired,
    input  logic [CW-1:0] tnow,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] ticks,
    output logic          closed,
    output logic          at_max
);
    localparam logic [CW-1:0] CMAX = '1;

    logic          prev;
    logic          opened;
    logic          rise;
    logic [CW-1:0] t_open;
    logic [CW-1:0] t_last;

    assign rise   = din & ~prev;
    assign at_max = (cnt == CMAX);
    assign ticks  = t_last - t_open;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev   <= 1'b0;
            opened <= 1'b0;
            closed <= 1'b0;
            cnt    <= '0;
            t_open <= '0;
            t_last <= '0;
        end else begin
            prev <= din;
            if (clr) begin
                opened <= 1'b0;
                closed <= 1'b0;
                cnt    <= '0;
                t_open <= '0;
                t_last <= '0;
            end else if (run) begin
                if (!recip) begin
                    if (rise && cnt_en && !at_max)
                        cnt <= cnt + 1'b1;
                end else if (!closed) begin
                    if (rise) begin
                        if (!opened) begin
                            opened <= 1'b1;
                            t_open <= tnow;
                            t_last <= tnow;
                        end else begin
                            if (!at_max)
                                cnt <= cnt + 1'b1;
                            t_last <= tnow;
                            if (expired)
                                closed <= 1'b1;
                        end
                    end else if (expired && !opened) begin
                        closed <= 1'b1;
                    end
                end
            end
        end
    end

    // R8: a saturated counter stays saturated until cleared
    p_cnt_sat_r8: assert property (@(posedge clk) disable iff (rst)
        (at_max && !clr) |=> at_max);

    // R5: a closed reciprocal channel freezes its results
    p_closed_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (closed && !clr) |=> ($stable(cnt) && $stable(ticks)));

    // R2: at most one edge is counted per cycle
    p_cnt_step_r2: assert property (@(posedge clk) disable iff (rst)
        !clr |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)));

endmodule

// File: rtl/fc_ctrl.sv
module fc_ctrl
    import fc_pkg::*;
#(
    parameter int              CW         = 64,
    parameter longint unsigned GATE_S_CYC = 64'd10_000_000,
    parameter longint unsigned GATE_M_CYC = 64'd100_000_000,
    parameter longint unsigned GATE_L_CYC = 64'd1_000_000_000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          stop,
    input  logic          all_closed,
    input  meas_cfg_t     cfg_in,
    output meas_cfg_t     cfg_q,
    output logic          clr,
    output logic          run,
    output logic          snap,
    output logic          expired,
    output logic [CW-1:0] t
);
    localparam logic [CW-1:0] TMAX  = '1;
    localparam logic [CW-1:0] LEN_S = CW'(GATE_S_CYC);
    localparam logic [CW-1:0] LEN_M = CW'(GATE_M_CYC);
    localparam logic [CW-1:0] LEN_L = CW'(GATE_L_CYC);

    ctl_state_e    st;
    logic [CW-1:0] glen;
    logic          m_direct, m_recip, m_event, finite, exp_now, finish;

    always_comb begin
        case (cfg_q.gate)
            G_SHORT: glen = LEN_S;
            G_MID:   glen = LEN_M;
            default: glen = LEN_L;
        endcase
    end

    assign m_recip  = (cfg_q.mode == M_RECIP);
    assign m_event  = (cfg_q.mode == M_EVENT);
    assign m_direct = is_direct(cfg_q.mode);
    assign finite   = (cfg_q.gate != G_INF) && !m_event;
    assign run      = (st == S_RUN);
    assign snap     = (st == S_SNAP);
    assign clr      = (st == S_IDLE) && start;
    assign exp_now  = run && finite && !expired && ((t + 1'b1) == glen);
    assign finish   = stop || (m_direct && exp_now) || (m_recip && expired && all_closed);

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            t       <= '0;
            expired <= 1'b0;
            cfg_q   <= '0;
        end else begin
            case (st)
                S_IDLE: if (start) begin
                    cfg_q   <= cfg_in;
                    t       <= '0;
                    expired <= 1'b0;
                    st      <= S_RUN;
                end
                S_RUN: begin
                    if (t != TMAX)
                        t <= t + 1'b1;
                    if (exp_now)
                        expired <= 1'b1;
                    if (finish)
                        st <= S_SNAP;
                end
                default: st <= S_IDLE;
            endcase
        end
    end

    // R3: a finite direct window never runs past its length
    p_gate_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (run && m_direct && finite) |-> (t < glen));

    // R6: event mode keeps running until stop
    p_event_runs_r6: assert property (@(posedge clk) disable iff (rst)
        (run && m_event && !stop) |=> run);

    // R4: time base never moves backwards while running
    p_time_mono_r4: assert property (@(posedge clk) disable iff (rst)
        run |=> (t >= $past(t)));

endmodule

// File: rtl/fc_multi_counter.sv
module fc_multi_counter
    import fc_pkg::*;
#(
    parameter int              NCH        = 18,
    parameter int              CW         = 64,
    parameter int              PW         = 8,
    parameter longint unsigned GATE_S_CYC = 64'd10_000_000,
    parameter longint unsigned GATE_M_CYC = 64'd100_000_000,
    parameter longint unsigned GATE_L_CYC = 64'd1_000_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    ch_in,
    input  logic [1:0]        cfg_mode,
    input  logic [1:0]        cfg_gate,
    input  logic              cfg_pat_en,
    input  logic [PW-1:0]     cfg_pat_mask,
    input  logic [PW-1:0]     cfg_pat_val,
    input  logic              start,
    input  logic              stop,
    output logic              busy,
    output logic              done,
    output logic              res_ovf,
    output logic [CW-1:0]     res_time,
    output logic [NCH*CW-1:0] res_cnt,
    output logic [NCH*CW-1:0] res_ticks
);
    localparam logic [CW-1:0] TMAX = '1;

    meas_cfg_t     cfg_in, cfg_q;
    logic          clr, run, snap, expired, pat_hit, cnt_en, m_recip;
    logic [CW-1:0] t;
    logic [PW-1:0] mask_q, val_q;
    logic [NCH-1:0] closed, at_max;
    logic [CW-1:0] ch_cnt   [NCH];
    logic [CW-1:0] ch_ticks [NCH];

    assign cfg_in = '{mode: meas_mode_e'(cfg_mode), gate: gate_sel_e'(cfg_gate), pat_en: cfg_pat_en};

    fc_ctrl #(
        .CW(CW), .GATE_S_CYC(GATE_S_CYC), .GATE_M_CYC(GATE_M_CYC), .GATE_L_CYC(GATE_L_CYC)
    ) u_ctrl (
        .clk(clk), .rst(rst), .start(start), .stop(stop), .all_closed(&closed),
        .cfg_in(cfg_in), .cfg_q(cfg_q), .clr(clr), .run(run), .snap(snap),
        .expired(expired), .t(t)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            mask_q <= '0;
            val_q  <= '0;
        end else if (clr) begin
            mask_q <= cfg_pat_mask;
            val_q  <= cfg_pat_val;
        end
    end

    assign pat_hit = (((ch_in[PW-1:0] ^ val_q) & mask_q) == '0);
    assign cnt_en  = !((cfg_q.mode == M_EVENT) && cfg_q.pat_en) || pat_hit;
    assign m_recip = (cfg_q.mode == M_RECIP);
    assign busy    = run || snap;

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        fc_chan #(.CW(CW)) u_ch (
            .clk(clk), .rst(rst), .din(ch_in[i]), .run(run), .clr(clr),
            .cnt_en(cnt_en), .recip(m_recip), .expired(expired), .tnow(t),
            .cnt(ch_cnt[i]), .ticks(ch_ticks[i]), .closed(closed[i]), .at_max(at_max[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            done      <= 1'b0;
            res_ovf   <= 1'b0;
            res_time  <= '0;
            res_cnt   <= '0;
            res_ticks <= '0;
        end else begin
            done <= snap;
            if (snap) begin
                res_ovf  <= (|at_max) || (t == TMAX);
                res_time <= t;
                for (int i = 0; i < NCH; i++) begin
                    res_cnt[i*CW +: CW]   <= ch_cnt[i];
                    res_ticks[i*CW +: CW] <= ch_ticks[i];
                end
            end
        end
    end

    // R9: done is a single-cycle pulse
    p_done_pulse_r9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R9: done only while idle
    p_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    // R9: results move only together with done
    p_res_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (!$stable(res_time) || !$stable(res_cnt) || !$stable(res_ovf)) |-> done);

    // R8: a saturated time base is always flagged
    p_ovf_flag_r8: assert property (@(posedge clk) disable iff (rst)
        (done && (res_time == TMAX)) |-> res_ovf);

endmodule

// File: tb/fc_multi_counter_test.sv
`timescale 1ns/1ps
module fc_multi_counter_test;
    localparam int NCH = 18;
    localparam int CW  = 12;
    localparam int PW  = 8;
    localparam int GS  = 40;
    localparam int GM  = 100;
    localparam int GL  = 200;
    localparam int TMX = (1 << CW) - 1;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    ch_in = '0;
    logic [1:0]        cfg_mode = '0;
    logic [1:0]        cfg_gate = '0;
    logic              cfg_pat_en = 1'b0;
    logic [PW-1:0]     cfg_pat_mask = '0;
    logic [PW-1:0]     cfg_pat_val = '0;
    logic              start = 1'b0;
    logic              stop = 1'b0;
    logic              busy, done, res_ovf;
    logic [CW-1:0]     res_time;
    logic [NCH*CW-1:0] res_cnt, res_ticks;

    always #4 clk = ~clk;

    fc_multi_counter #(
        .NCH(NCH), .CW(CW), .PW(PW),
        .GATE_S_CYC(GS), .GATE_M_CYC(GM), .GATE_L_CYC(GL)
    ) uut (
        .clk(clk), .rst(rst), .ch_in(ch_in), .cfg_mode(cfg_mode), .cfg_gate(cfg_gate),
        .cfg_pat_en(cfg_pat_en), .cfg_pat_mask(cfg_pat_mask), .cfg_pat_val(cfg_pat_val),
        .start(start), .stop(stop), .busy(busy), .done(done), .res_ovf(res_ovf),
        .res_time(res_time), .res_cnt(res_cnt), .res_ticks(res_ticks)
    );

    int s = 0, s0 = 0, se = 0, checks = 0, fails = 0, cyc = 0;
    logic [NCH-1:0] hold = '0;

    function automatic int per(input int i);
        return 2 + (i % 7);
    endfunction

    function automatic bit wv(input int i, input int ss);
        if (hold[i]) return 1'b0;
        return ((ss + i * 3) % per(i)) < (per(i) / 2);
    endfunction

    function automatic bit rs(input int i, input int ss);
        return wv(i, ss) && !wv(i, ss - 1);
    endfunction

    function automatic bit pm(input int ss, input logic [PW-1:0] m, input logic [PW-1:0] v);
        for (int j = 0; j < PW; j++)
            if (m[j] && (wv(j, ss) != v[j])) return 1'b0;
        return 1'b1;
    endfunction

    function automatic int exp_cnt(input int i, input int lo, input int hi, input bit pen,
                                   input logic [PW-1:0] m, input logic [PW-1:0] v);
        int n = 0;
        for (int ss = lo; ss <= hi; ss++)
            if (rs(i, ss) && (!pen || pm(ss, m, v))) n++;
        return n;
    endfunction

    task automatic check_eq(input string req, input string what, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_rng(input string req, input string what, input longint act,
                             input longint lo, input longint hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d..%0d", req, what, act, lo, hi);
        end
    endtask

    task automatic step();
        @(negedge clk);
        s++;
        for (int i = 0; i < NCH; i++) ch_in[i] = wv(i, s);
    endtask

    task automatic run_steps(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic begin_run(input logic [1:0] md, input logic [1:0] gt, input bit pen,
                             input logic [PW-1:0] m, input logic [PW-1:0] v);
        cfg_mode = md; cfg_gate = gt; cfg_pat_en = pen; cfg_pat_mask = m; cfg_pat_val = v;
        step();
        start = 1'b1;
        s0 = s;
        step();
        start = 1'b0;
    endtask

    task automatic stop_run();
        step();
        stop = 1'b1;
        se = s;
        step();
        stop = 1'b0;
    endtask

    task automatic wait_done(output int n);
        n = 0;
        do begin
            step();
            n++;
        end while (!done && n < 5000);
        check_eq("R9", "done seen", done, 1);
    endtask

    task automatic check_counts(input string req, input int lo, input int hi, input bit pen,
                                input logic [PW-1:0] m, input logic [PW-1:0] v);
        for (int i = 0; i < NCH; i++)
            check_eq(req, $sformatf("ch%0d count", i), res_cnt[i*CW +: CW], exp_cnt(i, lo, hi, pen, m, v));
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            checks++;
            $display("FAIL R9 watchdog: actual %0d cycles expected below 150000", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        int n;
        int glen;
        logic [CW-1:0]     sv_time;
        logic [NCH*CW-1:0] sv_cnt;

        run_steps(3);
        rst = 1'b0;
        step();
        // R1: reset state
        check_eq("R1", "busy", busy, 0);
        check_eq("R1", "done", done, 0);
        check_eq("R1", "res_time", res_time, 0);
        check_eq("R1", "res_cnt", (res_cnt == '0), 1);
        check_eq("R1", "res_ticks", (res_ticks == '0), 1);
        check_eq("R1", "res_ovf", res_ovf, 0);

        // R3 / R2: direct mode sweep over the three finite gates
        for (int g = 0; g < 3; g++) begin
            glen = (g == 0) ? GS : (g == 1) ? GM : GL;
            hold = (g == 1) ? 18'h0_0A05 : '0;
            begin_run(2'd0, 2'(g), 1'b0, '0, '0);
            wait_done(n);
            check_eq("R3", "done latency", n, glen + 1);
            check_eq("R3", "window time", res_time, glen);
            check_counts("R2", s0 + 1, s0 + glen, 1'b0, '0, '0);
            check_eq("R8", "no overflow", res_ovf, 0);
            step();
            check_eq("R9", "done single pulse", done, 0);
        end
        hold = '0;

        // R9: results held during a later run
        sv_time = res_time;
        sv_cnt  = res_cnt;
        begin_run(2'd0, 2'd2, 1'b0, '0, '0);
        run_steps(50);
        check_eq("R9", "busy during run", busy, 1);
        check_eq("R9", "time held", res_time, sv_time);
        check_eq("R9", "counts held", (res_cnt == sv_cnt), 1);
        check_eq("R9", "done low mid-run", done, 0);
        wait_done(n);
        check_eq("R9", "done after remaining window", n + 50, GL + 1);

        // R4: infinite gate, ends on stop
        begin_run(2'd0, 2'd3, 1'b0, '0, '0);
        run_steps(300);
        check_eq("R4", "still busy past longest gate", busy, 1);
        stop_run();
        wait_done(n);
        check_eq("R4", "time to stop", res_time, se - s0);
        check_counts("R4", s0 + 1, se, 1'b0, '0, '0);

        // R6: event mode ignores short gate
        begin_run(2'd2, 2'd0, 1'b0, '0, '0);
        run_steps(150);
        check_eq("R6", "still busy past gate", busy, 1);
        stop_run();
        wait_done(n);
        check_counts("R6", s0 + 1, se, 1'b0, '0, '0);

        // R7: pattern-qualified event counts, two patterns
        begin_run(2'd2, 2'd3, 1'b1, 8'h0F, 8'h05);
        run_steps(300);
        stop_run();
        wait_done(n);
        check_counts("R7", s0 + 1, se, 1'b1, 8'h0F, 8'h05);
        begin_run(2'd2, 2'd3, 1'b1, 8'hC0, 8'h80);
        run_steps(300);
        stop_run();
        wait_done(n);
        check_counts("R7", s0 + 1, se, 1'b1, 8'hC0, 8'h80);

        // R10: config changes and restart while busy are ignored
        begin_run(2'd0, 2'd0, 1'b0, '0, '0);
        run_steps(5);
        cfg_mode = 2'd2;
        cfg_gate = 2'd3;
        start = 1'b1;
        step();
        start = 1'b0;
        wait_done(n);
        check_eq("R10", "latency unchanged", n + 6, GS + 1);
        check_eq("R10", "time unchanged", res_time, GS);
        check_counts("R10", s0 + 1, s0 + GS, 1'b0, '0, '0);

        // R5: reciprocal mode, one channel silent
        hold = 18'h0_0010;
        begin_run(2'd1, 2'd0, 1'b0, '0, '0);
        wait_done(n);
        check_rng("R5", "recip completion", n, 1, 400);
        for (int i = 0; i < NCH; i++) begin
            if (hold[i]) begin
                check_eq("R5", $sformatf("silent ch%0d periods", i), res_cnt[i*CW +: CW], 0);
                check_eq("R5", $sformatf("silent ch%0d ticks", i), res_ticks[i*CW +: CW], 0);
            end else begin
                check_eq("R5", $sformatf("ch%0d ticks vs periods", i), res_ticks[i*CW +: CW],
                         res_cnt[i*CW +: CW] * per(i));
                check_rng("R5", $sformatf("ch%0d span", i), res_ticks[i*CW +: CW],
                          GS - 2 * per(i), GS + 2 * per(i));
            end
        end
        hold = '0;

        // R8: saturation of the time base
        begin_run(2'd2, 2'd3, 1'b0, '0, '0);
        run_steps(4200);
        stop_run();
        wait_done(n);
        check_eq("R8", "time saturates", res_time, TMX);
        check_eq("R8", "overflow flag", res_ovf, 1);
        check_eq("R8", "ch0 count", res_cnt[0 +: CW], exp_cnt(0, s0 + 1, se, 1'b0, '0, '0));

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule